// File: doc/BRIEF.md
# Slow-Tick Watchdog with Warn-Then-Reset Mode

This block is a watchdog that runs on the system clock and advances on a one-cycle enable pulse. The pulse arrives once per edge of a 32.768 kHz reference. A selectable prescaler divides those pulses, and each divided step advances a 16-bit up-counter. When the counter wraps from all-ones to zero it has overflowed. In immediate mode an overflow produces a one-cycle reset pulse. In delayed mode the first overflow raises an interrupt, and a reset pulse follows only at the next overflow, unless software refreshes the watchdog before then.

Software sees two writable registers through a single-cycle register port: a control register and an 8-bit reload register. A refresh is requested by writing 1 to the refresh bit. On the next slow tick the reload value enters the upper byte of the counter and the lower byte becomes zero. The same refresh clears a sticky timeout flag. That flag is kept through a system reset so that software can tell why the system restarted. Only the power-on reset or a refresh clears it.

A small state machine tracks the watchdog phase:
- STOPPED: the counter is halted.
- ARMED: the counter is running.
- WARNED: an overflow has been seen in delayed mode.
- FIRE: the one cycle in which the reset pulse is driven.

Transitions:
- STOPPED→ARMED when start is set.
- ARMED→STOPPED when start is cleared.
- ARMED→WARNED on an overflow in delayed mode.
- ARMED→FIRE on an overflow in immediate mode.
- WARNED→ARMED (or STOPPED if start is 0) on an applied refresh.
- WARNED→FIRE on a further overflow.
- FIRE→ARMED (or STOPPED if start is 0) after one cycle.

Top module: `slowtick_watchdog`

## Requirements
- R1: The prescale field (control bits 6:5) selects how many slow ticks make one counter step: 00 needs 256 ticks, 01 needs 64, 10 needs 8 and 11 needs 1. An applied refresh restarts the prescaler.
- R2: Writing control bit 1 as 1 sets a pending refresh, which reads back as 1. On the next tick the counter becomes {reload, 8'h00}, that tick does not count, and the bit reads 0 again.
- R3: The counter and prescaler advance only while the start bit (control bit 0) is 1. With start at 0, ticks leave the counter unchanged.
- R4: When the counter steps from 16'hFFFF it becomes 16'h0000 and keeps counting. That step sets the timeout status bit (control bit 2) in the same clock cycle.
- R5: With the delay bit (control bit 4) at 0, an overflow drives rst_pulse high for exactly one clock cycle. The rise follows the clock edge that samples the overflowing tick.
- R6: With the delay bit at 1, the first overflow raises irq and no reset. The next overflow without an intervening refresh drives a one-cycle rst_pulse.
- R7: An applied refresh clears the timeout status, drops irq, and cancels a pending delayed reset. After it, the following overflow only warns again.
- R8: A write cannot set or clear the timeout status bit.
- R9: System reset (rst_n low) clears every control bit, the reload register and the counter, but keeps the timeout status. Power-on reset (por_n low) clears everything, including the status.
- R10: irq is 1 exactly while the timeout status is 1 and the delay bit is 1.
- R11: The read map is address 0 for control, 1 for reload, 2 for the counter's high byte and 3 for its low byte. Control bits 7 and 3 always read 0. Writes go to addresses 0 and 1 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset, clears all state |
| rst_n | input | 1 | Active-low system reset, keeps timeout status |
| tick | input | 1 | One-cycle pulse per slow reference edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Timeout warning in delayed mode |
| rst_pulse | output | 1 | One-cycle watchdog reset request |

## Verification
The divider is tested by loading a known counter value and applying tick counts just below, at and above a multiple of each of the four ratios. The low counter byte then shows whether a step happened one tick early or late. Overflow is driven in both modes, and refresh is applied after a warning. This separates an immediate reset, a reset held back by the warning phase, and a warning cancelled by a refresh. System and power-on resets are applied while the timeout status is set, which shows whether the status is cleared by the right reset alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_ARMED   = 2'd1,
        ST_WARNED  = 2'd2,
        ST_FIRE    = 2'd3
    } wdt_state_t;

    localparam int PRE_W = 8;

    // Control register field positions
    localparam int CTL_START   = 0;
    localparam int CTL_REFRESH = 1;
    localparam int CTL_STATUS  = 2;
    localparam int CTL_DELAY   = 4;
    localparam int CTL_PRE_LO  = 5;
    localparam int CTL_PRE_HI  = 6;

    // Last prescaler count value before a counter step, per ratio select
    function automatic logic [PRE_W-1:0] pre_terminal(input logic [1:0] sel);
        logic [PRE_W-1:0] t;
        unique case (sel)
            2'b00: t = PRE_W'(255);
            2'b01: t = PRE_W'(63);
            2'b10: t = PRE_W'(7);
            2'b11: t = PRE_W'(0);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       step
);

    logic [PRE_W-1:0] pre_q;
    logic             at_end;

    assign at_end = (pre_q >= pre_terminal(sel));
    assign step   = tick && run && !clear && at_end;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else if (tick && run) begin
            pre_q <= at_end ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                arst_n,
    input  logic                load,
    input  logic [DATA_W-1:0]   reload,
    input  logic                step,
    output logic [2*DATA_W-1:0] cnt,
    output logic                wrap
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;

    assign cnt  = cnt_q;
    assign wrap = step && !load && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= {reload, {DATA_W{1'b0}}};
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       start,
    input  logic       delay_en,
    input  logic       wrap,
    input  logic       refresh_apply,
    output logic       rst_pulse,
    output wdt_state_t state
);

    wdt_state_t state_q;
    wdt_state_t state_d;

    assign state = state_q;

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (start) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (wrap)       state_d = delay_en ? ST_WARNED : ST_FIRE;
                else if (!start) state_d = ST_STOPPED;
            end
            ST_WARNED: begin
                if (refresh_apply) state_d = start ? ST_ARMED : ST_STOPPED;
                else if (wrap)     state_d = ST_FIRE;
            end
            ST_FIRE: begin
                state_d = start ? ST_ARMED : ST_STOPPED;
            end
        endcase
    end

    // Outputs
    always_comb begin
        rst_pulse = 1'b0;
        unique case (state_q)
            ST_FIRE:  rst_pulse = 1'b1;
            default:  rst_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/slowtick_watchdog.sv
module slowtick_watchdog
    import wdt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_pulse
);

    localparam int CNT_W = 2 * DATA_W;

    logic              sys_n;
    logic              start_q;
    logic              refresh_q;
    logic              delay_q;
    logic [1:0]        pre_sel_q;
    logic [DATA_W-1:0] reload_q;
    logic              status_q;
    logic              refresh_apply;
    logic              ctl_wr;
    logic              rld_wr;
    logic              step;
    logic              wrap;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] ctl_view;
    wdt_state_t        fsm_state;

    assign sys_n         = por_n & rst_n;
    assign refresh_apply = refresh_q && tick;
    assign ctl_wr        = wr_en && (addr == 2'd0);
    assign rld_wr        = wr_en && (addr == 2'd1);

    // Control and reload registers, cleared by either reset
    always_ff @(posedge clk or negedge sys_n) begin
        if (!sys_n) begin
            start_q   <= 1'b0;
            refresh_q <= 1'b0;
            delay_q   <= 1'b0;
            pre_sel_q <= 2'b00;
            reload_q  <= '0;
        end else begin
            if (refresh_apply) refresh_q <= 1'b0;
            if (ctl_wr) begin
                start_q   <= wdata[CTL_START];
                delay_q   <= wdata[CTL_DELAY];
                pre_sel_q <= wdata[CTL_PRE_HI:CTL_PRE_LO];
                if (wdata[CTL_REFRESH]) refresh_q <= 1'b1;
            end
            if (rld_wr) reload_q <= wdata;
        end
    end

    // Timeout status: only power-on reset or a refresh clears it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            status_q <= 1'b0;
        end else if (refresh_apply) begin
            status_q <= 1'b0;
        end else if (wrap) begin
            status_q <= 1'b1;
        end
    end

    wdt_prescaler u_pre (
        .clk    (clk),
        .arst_n (sys_n),
        .tick   (tick),
        .run    (start_q),
        .clear  (refresh_apply),
        .sel    (pre_sel_q),
        .step   (step)
    );

    wdt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk    (clk),
        .arst_n (sys_n),
        .load   (refresh_apply),
        .reload (reload_q),
        .step   (step),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    wdt_fsm u_fsm (
        .clk           (clk),
        .arst_n        (sys_n),
        .start         (start_q),
        .delay_en      (delay_q),
        .wrap          (wrap),
        .refresh_apply (refresh_apply),
        .rst_pulse     (rst_pulse),
        .state         (fsm_state)
    );

    assign irq = status_q && delay_q;

    always_comb begin
        ctl_view                         = '0;
        ctl_view[CTL_START]              = start_q;
        ctl_view[CTL_REFRESH]            = refresh_q;
        ctl_view[CTL_STATUS]             = status_q;
        ctl_view[CTL_DELAY]              = delay_q;
        ctl_view[CTL_PRE_HI:CTL_PRE_LO]  = pre_sel_q;
    end

    always_comb begin
        unique case (addr)
            2'd0: rdata = ctl_view;
            2'd1: rdata = reload_q;
            2'd2: rdata = cnt[CNT_W-1:DATA_W];
            2'd3: rdata = cnt[DATA_W-1:0];
        endcase
    end

endmodule

// File: rtl/wdt_checks.sv
module wdt_checks #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                por_n,
    input logic                rst_n,
    input logic                tick,
    input logic                start,
    input logic                refresh_pend,
    input logic                status,
    input logic                rst_pulse,
    input logic [2*DATA_W-1:0] cnt
);

    logic sys_n;
    assign sys_n = por_n & rst_n;

    // R5: the reset request never lasts beyond one cycle
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!sys_n)
        rst_pulse |=> !rst_pulse);

    // R4: a reset request only happens with the timeout recorded
    p_pulse_has_status_r4: assert property (@(posedge clk) disable iff (!sys_n)
        rst_pulse |-> status);

    // R8: status only falls after an applied refresh
    p_status_fall_r8: assert property (@(posedge clk) disable iff (!sys_n)
        $fell(status) |-> $past(refresh_pend && tick));

    // R2: an applied refresh zeroes the low counter byte and clears status
    p_refresh_load_r2: assert property (@(posedge clk) disable iff (!sys_n)
        (refresh_pend && tick) |=> (cnt[DATA_W-1:0] == '0) && !status);

    // R3: counter frozen while stopped, except for a refresh load
    p_frozen_r3: assert property (@(posedge clk) disable iff (!sys_n)
        (!start && !(refresh_pend && tick)) |=> $stable(cnt));

endmodule

bind slowtick_watchdog wdt_checks #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .rst_n        (rst_n),
    .tick         (tick),
    .start        (start_q),
    .refresh_pend (refresh_q),
    .status       (status_q),
    .rst_pulse    (rst_pulse),
    .cnt          (cnt)
);

// File: tb/slowtick_watchdog_tb.sv
module slowtick_watchdog_tb;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;
    logic       rst_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    slowtick_watchdog u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq       (irq),
        .rst_pulse (rst_pulse)
    );

    // {prescale select, ticks, expected low counter byte after reload 0xFF}
    localparam logic [19:0] VEC [9] = '{
        {2'b11, 10'd5,   8'd5},
        {2'b10, 10'd7,   8'd0},
        {2'b10, 10'd8,   8'd1},
        {2'b10, 10'd17,  8'd2},
        {2'b01, 10'd63,  8'd0},
        {2'b01, 10'd64,  8'd1},
        {2'b00, 10'd255, 8'd0},
        {2'b00, 10'd256, 8'd1},
        {2'b00, 10'd512, 8'd2}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Spaced ticks: one tick cycle, one idle cycle
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    // Back-to-back ticks, ending at a negedge right after the last tick edge
    task automatic ticks_fast(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R9, R11)
        rd(2'd0, v); chk("R9 ctrl after por", v, 8'h00);
        rd(2'd1, v); chk("R9 reload after por", v, 8'h00);
        rd(2'd3, v); chk("R9 cnt low after por", v, 8'h00);
        chk("R10 irq after por", irq, 1'b0);
        chk("R5 rst_pulse after por", rst_pulse, 1'b0);

        // R11 / R8: bits 7 and 3 read 0, status not settable
        wr(2'd0, 8'h9C);
        rd(2'd0, v); chk("R11 R8 ctrl unused bits and status", v, 8'h10);
        wr(2'd0, 8'h00);

        // R2 / R3: refresh with start=0, then stopped ticks
        wr(2'd1, 8'h12);
        wr(2'd0, 8'h02);
        rd(2'd0, v); chk("R2 refresh pending reads 1", v, 8'h02);
        ticks(1);
        rd(2'd0, v); chk("R2 refresh self-clears", v, 8'h00);
        rd(2'd2, v); chk("R2 cnt high loaded", v, 8'h12);
        rd(2'd3, v); chk("R2 cnt low zero", v, 8'h00);
        ticks(4);
        rd(2'd3, v); chk("R3 stopped counter frozen", v, 8'h00);
        wr(2'd0, 8'h61);
        ticks(3);
        rd(2'd3, v); chk("R3 running counts", v, 8'h03);
        wr(2'd0, 8'h60);
        ticks(3);
        rd(2'd3, v); chk("R3 stopped again", v, 8'h03);

        // R1: prescale ratio table
        wr(2'd1, 8'hFF);
        for (int k = 0; k < 9; k++) begin
            logic [1:0] ps;
            ps = VEC[k][19:18];
            wr(2'd0, {1'b0, ps, 5'b00011});
            ticks(1);
            ticks(int'(VEC[k][17:8]));
            rd(2'd3, v); chk("R1 prescale low byte", v, {8'h00, VEC[k][7:0]});
            rd(2'd2, v); chk("R1 prescale high byte", v, 8'hFF);
        end

        // R4 / R5: immediate mode overflow
        wr(2'd0, 8'h63);
        ticks(1);
        ticks(255);
        chk("R5 no pulse before overflow", rst_pulse, 1'b0);
        rd(2'd0, v); chk("R4 status clear before overflow", v, 8'h61);
        ticks(1);
        chk("R5 pulse on overflow", rst_pulse, 1'b1);
        rd(2'd0, v); chk("R4 status set on overflow", v, 8'h65);
        chk("R10 no irq in immediate mode", irq, 1'b0);
        @(negedge clk);
        chk("R5 pulse one cycle", rst_pulse, 1'b0);
        rd(2'd2, v); chk("R4 wrapped high", v, 8'h00);
        ticks(2);
        rd(2'd3, v); chk("R4 keeps counting", v, 8'h02);

        // R8: writing status bit 0 does not clear it
        wr(2'd0, 8'h61);
        rd(2'd0, v); chk("R8 status not clearable", v, 8'h65);

        // R9: system reset keeps status
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0, v); chk("R9 sysreset keeps status", v, 8'h04);
        rd(2'd1, v); chk("R9 sysreset clears reload", v, 8'h00);
        rd(2'd2, v); chk("R9 sysreset clears cnt", v, 8'h00);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd(2'd0, v); chk("R9 por clears status", v, 8'h00);

        // R6 / R7 / R10: delayed mode
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h73);
        ticks(1);
        ticks(256);
        chk("R6 no reset at first overflow", rst_pulse, 1'b0);
        chk("R6 R10 irq at first overflow", irq, 1'b1);
        rd(2'd0, v); chk("R6 status set", v, 8'h75);
        wr(2'd0, 8'h73);
        ticks(1);
        chk("R7 irq dropped by refresh", irq, 1'b0);
        rd(2'd0, v); chk("R7 status cleared by refresh", v, 8'h71);
        ticks(256);
        chk("R7 warning again, no reset", rst_pulse, 1'b0);
        chk("R7 irq again", irq, 1'b1);
        ticks_fast(65535);
        chk("R6 no reset before second overflow", rst_pulse, 1'b0);
        ticks(1);
        chk("R6 reset at second overflow", rst_pulse, 1'b1);
        chk("R10 irq held", irq, 1'b1);
        @(negedge clk);
        chk("R6 reset one cycle", rst_pulse, 1'b0);
        wr(2'd0, 8'h61);
        chk("R10 irq off with delay cleared", irq, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule